// File: doc/BRIEF.md
# Write Protect Command Sequencer

This block sits in front of the page loader of a byte-wide nonvolatile memory controller. It watches every qualified write strobe (address and data) and recognizes two fixed command handshakes. The three-write lock handshake puts the memory into the protected state. It also opens a single page-load window for up to 128 data bytes. The six-write release handshake returns the memory to the open mode, where writes pass freely.

For each write strobe, the block decides in the same cycle whether the write may go to the page loader (`wr_permit_o`). It also decides whether the write was taken as a command step and must stay out of the array (`cmd_absorb_o`). The protect flag resets to the open state. Its value can be preloaded from an external keeper of the persistent setting.

A write that does not fit the expected next step drops the sequencer back to idle. That write is then handled as an ordinary write under the current protect state. Address bit 15 is not compared when sequence addresses are matched.

Top module: `wp_cmd_seq`

## Requirements
- R1: After reset `protect_o` is 0 and no command step is pending.
- R2: While `protect_o` is 0, a strobe that is not a command step gives `wr_permit_o`=1 and `cmd_absorb_o`=0 in the same cycle.
- R3: A strobe that matches the expected command step gives `cmd_absorb_o`=1 and `wr_permit_o`=0 in the same cycle.
- R4: The lock handshake is three writes: 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. After the third write, `protect_o` is 1 from the next cycle on, and a page-load window is open.
- R5: While `protect_o` is 1 and no window is open, a non-command strobe gives `wr_permit_o`=0 and `cmd_absorb_o`=0.
- R6: An open window permits exactly 128 ordinary writes. The 129th write is blocked.
- R7: A pulse on `load_done_i` closes the window. Later ordinary writes are blocked and `protect_o` stays 1.
- R8: The release handshake is six writes: 0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA, 0x20 to 0x5555. After the sixth write, `protect_o` is 0 from the next cycle on.
- R9: Address bit 15 is ignored when sequence addresses are matched.
- R10: A strobe that breaks the expected step is treated as an ordinary write under the current state, and the sequencer returns to idle.
- R11: When `preload_en_i` is 1 at a clock edge, `protect_o` takes the value of `preload_val_i` and any open window closes.
- R12: The third step branches on its data. 0xA0 ends the lock handshake. 0x80 continues the release handshake and does not set protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | One-cycle qualified write strobe |
| wr_addr_i | input | 16 | Write address |
| wr_data_i | input | 8 | Write data |
| load_done_i | input | 1 | Pulse marking the end of a page load |
| preload_en_i | input | 1 | Load the protect flag from the persistent keeper |
| preload_val_i | input | 1 | Value to load into the protect flag |
| wr_permit_o | output | 1 | Write may go to the page loader |
| protect_o | output | 1 | Current protect state |
| cmd_absorb_o | output | 1 | Write was taken as a command step |

## Verification
The assertions rely on two assumptions about the inputs. First, `wr_valid_i` is a single-cycle strobe. Second, `preload_en_i` is used only between handshakes, never in the middle of one. The stimulus keeps to both: it raises each strobe for exactly one clock, drives all inputs on the falling edge, and issues preloads only when the sequencer is idle.

Because of these assumptions, a window may always be taken as implying protection, and the byte count may always be taken as bounded by the page size. The permit and absorb outputs are combinational. They are checked before the rising edge, and the protect flag is checked just after it.

// File: rtl/wp_cmd_pkg.sv
package wp_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_K1   = 3'd1,
    ST_K2   = 3'd2,
    ST_R3   = 3'd3,
    ST_R4   = 3'd4,
    ST_R5   = 3'd5
  } step_e;

  localparam logic [7:0]  KEY_HI   = 8'hAA;
  localparam logic [7:0]  KEY_LO   = 8'h55;
  localparam logic [7:0]  OP_LOCK  = 8'hA0;
  localparam logic [7:0]  OP_EXT   = 8'h80;
  localparam logic [7:0]  OP_FREE  = 8'h20;
  localparam logic [15:0] ADR_ODD  = 16'h5555;
  localparam logic [15:0] ADR_EVEN = 16'h2AAA;
endpackage

// File: rtl/wp_step_match.sv
module wp_step_match
  import wp_cmd_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter bit IGNORE_MSB = 1'b1
) (
  input  step_e             step_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              hit_o,
  output step_e             nxt_o,
  output logic              lock_o,
  output logic              free_o
);
  localparam logic [ADDR_W-1:0] A_ODD  = ADDR_W'(ADR_ODD);
  localparam logic [ADDR_W-1:0] A_EVEN = ADDR_W'(ADR_EVEN);

  logic [ADDR_W-1:0] addr_m, odd_m, even_m;

  generate
    if (IGNORE_MSB) begin : g_mask
      assign addr_m = {1'b0, addr_i[ADDR_W-2:0]};
      assign odd_m  = {1'b0, A_ODD[ADDR_W-2:0]};
      assign even_m = {1'b0, A_EVEN[ADDR_W-2:0]};
    end else begin : g_full
      assign addr_m = addr_i;
      assign odd_m  = A_ODD;
      assign even_m = A_EVEN;
    end
  endgenerate

  logic at_odd, at_even;
  assign at_odd  = (addr_m == odd_m);
  assign at_even = (addr_m == even_m);

  always_comb begin
    hit_o  = 1'b0;
    nxt_o  = ST_IDLE;
    lock_o = 1'b0;
    free_o = 1'b0;
    unique case (step_i)
      ST_IDLE: begin
        hit_o = at_odd && (data_i == DATA_W'(KEY_HI));
        nxt_o = ST_K1;
      end
      ST_K1: begin
        hit_o = at_even && (data_i == DATA_W'(KEY_LO));
        nxt_o = ST_K2;
      end
      ST_K2: begin
        // third step decides between lock and the longer release path
        hit_o  = at_odd && ((data_i == DATA_W'(OP_LOCK)) || (data_i == DATA_W'(OP_EXT)));
        lock_o = hit_o && (data_i == DATA_W'(OP_LOCK));
        nxt_o  = lock_o ? ST_IDLE : ST_R3;
      end
      ST_R3: begin
        hit_o = at_odd && (data_i == DATA_W'(KEY_HI));
        nxt_o = ST_R4;
      end
      ST_R4: begin
        hit_o = at_even && (data_i == DATA_W'(KEY_LO));
        nxt_o = ST_R5;
      end
      ST_R5: begin
        hit_o  = at_odd && (data_i == DATA_W'(OP_FREE));
        free_o = hit_o;
        nxt_o  = ST_IDLE;
      end
      default: begin
        hit_o = 1'b0;
        nxt_o = ST_IDLE;
      end
    endcase
  end
endmodule

// File: rtl/wp_window.sv
module wp_window #(
  parameter int PAGE_BYTES = 128,
  localparam int CNT_W     = $clog2(PAGE_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             kill_i,
  input  logic             open_i,
  input  logic             done_i,
  input  logic             byte_i,
  output logic             open_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic last_byte;
  assign last_byte = byte_i && (cnt_o == CNT_W'(PAGE_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o <= 1'b0;
      cnt_o  <= '0;
    end else if (kill_i) begin
      open_o <= 1'b0;
      cnt_o  <= '0;
    end else if (open_i) begin
      open_o <= 1'b1;
      cnt_o  <= '0;
    end else if (done_i || last_byte) begin
      open_o <= 1'b0;
      cnt_o  <= '0;
    end else if (byte_i) begin
      cnt_o  <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/wp_flag.sv
module wp_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_i,
  input  logic ld_val_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= RST_VAL;
    else if (ld_i)   q_o <= ld_val_i;
    else if (clr_i)  q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
  end
endmodule

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq
  import wp_cmd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 128,
  parameter bit IGNORE_MSB  = 1'b1,
  parameter bit PROTECT_RST = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_done_i,
  input  logic              preload_en_i,
  input  logic              preload_val_i,
  output logic              wr_permit_o,
  output logic              protect_o,
  output logic              cmd_absorb_o
);
  localparam int CNT_W = $clog2(PAGE_BYTES + 1);

  step_e            step_q, step_nxt;
  logic             m_hit, m_lock, m_free;
  logic             hit, lock_evt, free_evt;
  logic             win_open;
  logic [CNT_W-1:0] win_cnt;

  wp_step_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IGNORE_MSB(IGNORE_MSB)
  ) u_match (
    .step_i(step_q), .addr_i(wr_addr_i), .data_i(wr_data_i),
    .hit_o(m_hit), .nxt_o(step_nxt), .lock_o(m_lock), .free_o(m_free)
  );

  assign hit      = wr_valid_i && m_hit;
  assign lock_evt = hit && m_lock;
  assign free_evt = hit && m_free;

  assign cmd_absorb_o = hit;
  assign wr_permit_o  = wr_valid_i && !hit && (!protect_o || win_open);

  // a broken step falls back to idle; the strobe itself is handled above
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           step_q <= ST_IDLE;
    else if (preload_en_i) step_q <= ST_IDLE;
    else if (wr_valid_i)   step_q <= hit ? step_nxt : ST_IDLE;
  end

  wp_window #(.PAGE_BYTES(PAGE_BYTES)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .kill_i(preload_en_i || free_evt),
    .open_i(lock_evt),
    .done_i(load_done_i),
    .byte_i(wr_permit_o && win_open),
    .open_o(win_open),
    .cnt_o(win_cnt)
  );

  wp_flag #(.RST_VAL(PROTECT_RST)) u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ld_i(preload_en_i), .ld_val_i(preload_val_i),
    .set_i(lock_evt), .clr_i(free_evt),
    .q_o(protect_o)
  );
endmodule

// File: rtl/wp_cmd_seq_chk.sv
module wp_cmd_seq_chk #(
  parameter int PAGE_BYTES = 128,
  localparam int CNT_W     = $clog2(PAGE_BYTES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_valid_i,
  input logic             load_done_i,
  input logic             preload_en_i,
  input logic             wr_permit_o,
  input logic             protect_o,
  input logic             cmd_absorb_o,
  input logic             win_open,
  input logic [CNT_W-1:0] win_cnt
);
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |-> (!wr_permit_o && !cmd_absorb_o));

  p_absorb_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_absorb_o |-> !wr_permit_o);

  p_open_permit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !protect_o && !cmd_absorb_o) |-> wr_permit_o);

  p_blocked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (protect_o && !win_open) |-> !wr_permit_o);

  p_window_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_open |-> protect_o);

  p_done_closes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_done_i && !cmd_absorb_o) |=> !win_open);

  p_count_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_cnt < CNT_W'(PAGE_BYTES));

  p_preload_kill_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preload_en_i |=> !win_open);
endmodule

bind wp_cmd_seq wp_cmd_seq_chk #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i),
  .load_done_i(load_done_i), .preload_en_i(preload_en_i),
  .wr_permit_o(wr_permit_o), .protect_o(protect_o),
  .cmd_absorb_o(cmd_absorb_o), .win_open(win_open), .win_cnt(win_cnt)
);

// File: tb/wp_cmd_seq_test.sv
module wp_cmd_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        load_done = 1'b0;
  logic        pre_en = 1'b0;
  logic        pre_val = 1'b0;
  logic        permit, prot, absorb;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  wp_cmd_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .load_done_i(load_done), .preload_en_i(pre_en),
    .preload_val_i(pre_val), .wr_permit_o(permit), .protect_o(prot),
    .cmd_absorb_o(absorb)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one strobe: outputs checked before the edge, strobe dropped after it
  task automatic wr(input logic [15:0] a, input logic [7:0] d,
                    input bit exp_permit, input bit exp_absorb, input string req);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    #1;
    chk({req, " permit"}, int'(permit), int'(exp_permit));
    chk({req, " absorb"}, int'(absorb), int'(exp_absorb));
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic lock_seq(input logic [15:0] msb, input string req);
    wr(16'h5555 | msb, 8'hAA, 0, 1, req);
    wr(16'h2AAA | msb, 8'h55, 0, 1, req);
    wr(16'h5555 | msb, 8'hA0, 0, 1, req);
  endtask

  task automatic free_seq(input string req);
    wr(16'h5555, 8'hAA, 0, 1, req);
    wr(16'h2AAA, 8'h55, 0, 1, req);
    wr(16'h5555, 8'h80, 0, 1, req);
    wr(16'h5555, 8'hAA, 0, 1, req);
    wr(16'h2AAA, 8'h55, 0, 1, req);
    wr(16'h5555, 8'h20, 0, 1, req);
  endtask

  task automatic t_reset;
    chk("R1 protect after reset", int'(prot), 0);
    wr(16'h1234, 8'h5A, 1, 0, "R2 open write");
    wr(16'h5555, 8'h00, 1, 0, "R2 open write at cmd addr");
    chk("R1 still open", int'(prot), 0);
  endtask

  task automatic t_break_open;
    wr(16'h5555, 8'hAA, 0, 1, "R3 first step absorbed");
    wr(16'h1000, 8'h77, 1, 0, "R10 broken step ordinary open");
    wr(16'h2AAA, 8'h55, 1, 0, "R10 sequencer idle after break");
  endtask

  task automatic t_branch;
    wr(16'h5555, 8'hAA, 0, 1, "R12 step1");
    wr(16'h2AAA, 8'h55, 0, 1, "R12 step2");
    wr(16'h5555, 8'h80, 0, 1, "R12 ext step absorbed");
    chk("R12 ext does not lock", int'(prot), 0);
    wr(16'h5555, 8'hAA, 0, 1, "R12 step4");
    wr(16'h2AAA, 8'h55, 0, 1, "R12 step5");
    wr(16'h5555, 8'h20, 0, 1, "R12 step6");
    chk("R12 still open", int'(prot), 0);
  endtask

  task automatic t_lock_full_page;
    lock_seq(16'h0000, "R3 lock step");
    chk("R4 protect after lock", int'(prot), 1);
    for (int i = 0; i < 128; i++)
      wr(16'h0300 + 16'(i), 8'(i), 1, 0, "R6 window write");
    wr(16'h0380, 8'h11, 0, 0, "R6 byte 129 blocked");
    chk("R6 protect kept", int'(prot), 1);
  endtask

  task automatic t_blocked;
    wr(16'h4000, 8'h33, 0, 0, "R5 protected write blocked");
    wr(16'h0001, 8'h44, 0, 0, "R5 second blocked write");
  endtask

  task automatic t_msb_window_done;
    lock_seq(16'h8000, "R9 lock with bit15 set");
    chk("R9 protect", int'(prot), 1);
    wr(16'h0500, 8'h01, 1, 0, "R9 window opened");
    wr(16'h0501, 8'h02, 1, 0, "R7 window write");
    @(negedge clk); load_done = 1'b1;
    @(posedge clk); #1; load_done = 1'b0;
    wr(16'h0502, 8'h03, 0, 0, "R7 blocked after load done");
    chk("R7 protect kept", int'(prot), 1);
  endtask

  task automatic t_break_prot;
    wr(16'h5555, 8'hAA, 0, 1, "R3 step1 protected");
    wr(16'h2AAA, 8'h12, 0, 0, "R10 broken step blocked");
    wr(16'h2AAA, 8'h55, 0, 0, "R10 idle after break protected");
  endtask

  task automatic t_free;
    wr(16'h5555, 8'hAA, 0, 1, "R8 step1");
    wr(16'h2AAA, 8'h55, 0, 1, "R8 step2");
    wr(16'h5555, 8'h80, 0, 1, "R8 step3");
    chk("R12 ext keeps protect", int'(prot), 1);
    wr(16'h5555, 8'hAA, 0, 1, "R8 step4");
    wr(16'h2AAA, 8'h55, 0, 1, "R8 step5");
    chk("R8 protect before last", int'(prot), 1);
    wr(16'h5555, 8'h20, 0, 1, "R8 step6");
    chk("R8 protect cleared", int'(prot), 0);
    wr(16'h0777, 8'h99, 1, 0, "R8 open after release");
  endtask

  task automatic t_preload;
    @(negedge clk); pre_en = 1'b1; pre_val = 1'b1;
    @(posedge clk); #1; pre_en = 1'b0;
    chk("R11 preload set", int'(prot), 1);
    wr(16'h0100, 8'h10, 0, 0, "R11 blocked after preload");
    lock_seq(16'h0000, "R11 lock");
    wr(16'h0100, 8'h10, 1, 0, "R11 window open");
    @(negedge clk); pre_en = 1'b1; pre_val = 1'b1;
    @(posedge clk); #1; pre_en = 1'b0;
    wr(16'h0101, 8'h10, 0, 0, "R11 preload closes window");
    @(negedge clk); pre_en = 1'b1; pre_val = 1'b0;
    @(posedge clk); #1; pre_en = 1'b0;
    chk("R11 preload clear", int'(prot), 0);
    wr(16'h0102, 8'h10, 1, 0, "R11 open after preload");
    free_seq("R8 release from open");
    chk("R8 open stays open", int'(prot), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_break_open();
    t_branch();
    t_lock_full_page();
    t_blocked();
    t_msb_window_done();
    t_break_prot();
    t_free();
    t_preload();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule